// File: doc/BRIEF.md
# Disk interface state-line latch

This block holds the eight control lines of a disk interface chip. Software never writes data to these lines. The address of a bus access alone says which line changes and which level it takes. The data bus plays no part. A read and a write have the same effect.

The block watches a chip select and a 24-bit address. When the chip select is high and the address falls in the block's region, one line is updated at the clock edge that ends the access. The eight lines leave the block as one vector. A registered 2-bit mode code is also produced from the two highest lines, for use by a read-data path.

Top module: `disk_state_latch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight lines and the mode code become 0.
- R2: An access is qualified when `bus_cs` is high and address bits [23:20] equal 4'hD.
- R3: On a qualified access, address bits [12:10] pick the line index. Index 0 to 2 are the three phase lines, 3 is the phase strobe, 4 is motor enable, 5 is drive select, 6 is mode-low and 7 is mode-high.
- R4: On a qualified access, the picked line takes the value of address bit 9. An address ending in 0x1FF clears the line, and the address 0x200 above it sets the line.
- R5: A qualified access leaves the other seven lines unchanged. Repeating the same access leaves all lines as they are.
- R6: While `bus_cs` is low, no line changes, whatever the address.
- R7: With `bus_cs` high and address bits [23:20] not equal to 4'hD, no line changes.
- R8: `mode` always equals {line 7, line 6}. It is registered at the same edge as the lines. Code 00 selects the data register, 01 the status register, 10 the handshake register and 11 write load.
- R9: An access presented before a rising edge shows on `lines` only after that edge.
- R10: When a qualified access and reset fall on the same edge, reset wins and all lines become 0.
- R11: Address bits [19:13] and [8:0] have no effect on which line changes or on its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select for the current bus access |
| bus_addr | input | 24 | Bus address |
| lines | output | 8 | Current state of the eight control lines |
| mode | output | 2 | Registered {line 7, line 6} mode code |

## Verification
Two events can meet at one clock edge: a qualified access and reset. The bench raises `rst_n` low on the same edge as an access that would set line 0, with other lines already set beforehand. It then expects every line and the mode code to read zero. An access to line 6 or line 7 also changes `mode` at the edge where the line itself changes. The bench therefore checks `mode` against the expected line vector after each access of the sweep, and never one cycle later.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  // Mode code formed from {mode-high, mode-low} lines.
  typedef enum logic [1:0] {
    SENSE_DATA      = 2'b00,
    SENSE_STATUS    = 2'b01,
    SENSE_HANDSHAKE = 2'b10,
    LOAD_WRITE      = 2'b11
  } sense_mode_e;

  // Line roles by index; decode order depends on these positions.
  localparam int unsigned LINE_PHASE_A  = 0;
  localparam int unsigned LINE_PHASE_B  = 1;
  localparam int unsigned LINE_PHASE_C  = 2;
  localparam int unsigned LINE_STROBE   = 3;
  localparam int unsigned LINE_MOTOR    = 4;
  localparam int unsigned LINE_DRIVE    = 5;
  localparam int unsigned LINE_MODE_LO  = 6;
  localparam int unsigned LINE_MODE_HI  = 7;

endpackage

// File: rtl/dsl_region_dec.sv
module dsl_region_dec #(
  parameter int unsigned REGION_W = 4,
  parameter logic [REGION_W-1:0] REGION_VAL = 4'hD
) (
  input  logic                cs,
  input  logic [REGION_W-1:0] region_field,
  output logic                hit
);

  function automatic logic region_match(input logic [REGION_W-1:0] f);
    return f == REGION_VAL;
  endfunction

  assign hit = cs & region_match(region_field);

endmodule

// File: rtl/dsl_slot_dec.sv
module dsl_slot_dec #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned SEL_W = $clog2(NUM_LINES)
) (
  input  logic [SEL_W-1:0]     sel_field,
  input  logic                 level_bit,
  output logic [SEL_W-1:0]     idx,
  output logic                 level,
  output logic [NUM_LINES-1:0] onehot
);

  function automatic logic [NUM_LINES-1:0] one_of(input logic [SEL_W-1:0] s);
    logic [NUM_LINES-1:0] r;
    r = '0;
    r[s] = 1'b1;
    return r;
  endfunction

  assign idx    = sel_field;
  assign level  = level_bit;
  assign onehot = one_of(sel_field);

endmodule

// File: rtl/dsl_line_bank.sv
module dsl_line_bank #(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned MODE_LO_IDX = 6,
  parameter int unsigned MODE_HI_IDX = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [NUM_LINES-1:0] onehot,
  input  logic                 level,
  output logic [NUM_LINES-1:0] lines_q,
  output logic [1:0]           mode_q
);

  logic [NUM_LINES-1:0] lines_nxt;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_comb begin
      lines_nxt[g] = (we && onehot[g]) ? level : lines_q[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) lines_q[g] <= 1'b0;
      else        lines_q[g] <= lines_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= dsl_pkg::SENSE_DATA;
    else        mode_q <= {lines_nxt[MODE_HI_IDX], lines_nxt[MODE_LO_IDX]};
  end

endmodule

// File: rtl/disk_state_latch.sv
module disk_state_latch #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned REGION_LSB  = 20,
  parameter int unsigned REGION_W    = 4,
  parameter logic [REGION_W-1:0] REGION_VAL = 4'hD,
  parameter int unsigned SLOT_LSB    = 10,
  parameter int unsigned LEVEL_BIT   = 9,
  parameter int unsigned MODE_LO_IDX = dsl_pkg::LINE_MODE_LO,
  parameter int unsigned MODE_HI_IDX = dsl_pkg::LINE_MODE_HI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_LINES-1:0] lines,
  output logic [1:0]           mode
);

  localparam int unsigned SEL_W = $clog2(NUM_LINES);

  // Decoded events, named for the bound checker.
  logic                 acc_hit;
  logic [SEL_W-1:0]     acc_idx;
  logic                 acc_val;
  logic [NUM_LINES-1:0] acc_onehot;
  logic                 unused_addr_bits;

  assign unused_addr_bits = ^bus_addr;

  dsl_region_dec #(
    .REGION_W   (REGION_W),
    .REGION_VAL (REGION_VAL)
  ) u_region (
    .cs           (bus_cs),
    .region_field (bus_addr[REGION_LSB +: REGION_W]),
    .hit          (acc_hit)
  );

  dsl_slot_dec #(
    .NUM_LINES (NUM_LINES)
  ) u_slot (
    .sel_field (bus_addr[SLOT_LSB +: SEL_W]),
    .level_bit (bus_addr[LEVEL_BIT]),
    .idx       (acc_idx),
    .level     (acc_val),
    .onehot    (acc_onehot)
  );

  dsl_line_bank #(
    .NUM_LINES   (NUM_LINES),
    .MODE_LO_IDX (MODE_LO_IDX),
    .MODE_HI_IDX (MODE_HI_IDX)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (acc_hit),
    .onehot  (acc_onehot),
    .level   (acc_val),
    .lines_q (lines),
    .mode_q  (mode)
  );

endmodule

// File: rtl/disk_state_latch_chk.sv
module disk_state_latch_chk #(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned MODE_LO_IDX = 6,
  parameter int unsigned MODE_HI_IDX = 7,
  localparam int unsigned SEL_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_cs,
  input logic                 acc_hit,
  input logic [SEL_W-1:0]     acc_idx,
  input logic                 acc_val,
  input logic [NUM_LINES-1:0] lines,
  input logic [1:0]           mode
);

  localparam logic [NUM_LINES-1:0] LINE_ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (lines == '0 && mode == 2'b00)); // R1

  AST_NO_CS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> !acc_hit); // R6

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |=> $stable(lines)); // R7

  AST_TARGET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> lines[$past(acc_idx)] == $past(acc_val)); // R4

  AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> ((lines ^ $past(lines)) & ~(LINE_ONE << $past(acc_idx))) == '0); // R5

  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == {lines[MODE_HI_IDX], lines[MODE_LO_IDX]}); // R8

endmodule

bind disk_state_latch disk_state_latch_chk #(
  .NUM_LINES   (NUM_LINES),
  .MODE_LO_IDX (MODE_LO_IDX),
  .MODE_HI_IDX (MODE_HI_IDX)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_cs  (bus_cs),
  .acc_hit (acc_hit),
  .acc_idx (acc_idx),
  .acc_val (acc_val),
  .lines   (lines),
  .mode    (mode)
);

// File: tb/disk_state_latch_bench.sv
module disk_state_latch_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cs;
  logic [23:0] bus_addr;
  wire  [7:0]  lines;
  wire  [1:0]  mode;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  disk_state_latch u_disk_state_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs   (bus_cs),
    .bus_addr (bus_addr),
    .lines    (lines),
    .mode     (mode)
  );

  task automatic check(input string req, input logic [7:0] exp_l);
    logic [1:0] exp_m;
    exp_m = {exp_l[7], exp_l[6]};
    checks++;
    if (lines !== exp_l || mode !== exp_m) begin
      fails++;
      $display("FAIL %s lines=%h mode=%b expected lines=%h mode=%b",
               req, lines, mode, exp_l, exp_m);
    end
  endtask

  function automatic logic [23:0] line_addr(input int idx, input bit lvl);
    int a;
    a = 32'hDFE1FF + idx * 32'h400 + (lvl ? 32'h200 : 0);
    return a[23:0];
  endfunction

  // Drive at a falling edge, let one rising edge pass, update the model.
  task automatic access(input logic [23:0] a, input logic c);
    int ai;
    bus_addr = a;
    bus_cs   = c;
    @(negedge clk);
    bus_cs = 1'b0;
    ai = int'(a);
    if (c && (ai >> 20) == 13)
      model[(ai >> 10) % 8] = ((ai >> 9) % 2) == 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] saved;
    rst_n = 1'b0; bus_cs = 1'b0; bus_addr = '0; model = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: no change before the edge, change after it.
    bus_addr = line_addr(4, 1'b1);
    bus_cs   = 1'b1;
    #1 check("R9 before edge", model);
    @(negedge clk);
    bus_cs = 1'b0;
    model[4] = 1'b1;
    check("R9 after edge", model);

    // R2 R3 R4 R5 R8: drive every 8-bit pattern line by line.
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pv;
      pv = 8'(p);
      for (int i = 0; i < 8; i++) begin
        access(line_addr(i, pv[i]), 1'b1);
        check("R2 R3 R4 R5 R8 sweep", model);
      end
      checks++;
      if (model !== pv) begin
        fails++;
        $display("FAIL R3 pattern model=%h expected=%h", model, pv);
      end
    end

    // R5: repeated identical accesses.
    for (int i = 0; i < 8; i++) access(line_addr(i, i % 2 == 0), 1'b1);
    for (int k = 0; k < 3; k++) begin
      access(line_addr(2, 1'b1), 1'b1);
      check("R5 repeat", model);
    end

    // R6: chip select low, every line address, flipping each line.
    saved = model;
    for (int k = 0; k < 8; k++) begin
      access(line_addr(k, !saved[k]), 1'b0);
      check("R6 no select", saved);
    end

    // R7: chip select high, outside the region.
    for (int k = 0; k < 16; k++) begin
      logic [23:0] la;
      logic [3:0]  nib;
      la  = line_addr(k % 8, !model[k % 8]);
      nib = (k % 4 == 0) ? 4'hC : (k % 4 == 1) ? 4'hE : (k % 4 == 2) ? 4'h5 : 4'hF;
      saved = model;
      access({nib, la[19:0]}, 1'b1);
      check("R7 out of region", saved);
    end

    // R11: other address bits varied inside the region.
    for (int k = 0; k < 32; k++) begin
      logic [23:0] a;
      a = {4'hD, 7'(k * 19 + 3), 3'(k % 8), 1'((k / 8) % 2), 9'(k * 37)};
      access(a, 1'b1);
      check("R11 alias bits", model);
    end

    // R10: reset and a qualified access on one edge.
    for (int i = 0; i < 8; i++) access(line_addr(i, 1'b1), 1'b1);
    check("R10 setup", 8'hFF);
    bus_addr = line_addr(0, 1'b1);
    bus_cs   = 1'b1;
    rst_n    = 1'b0;
    @(negedge clk);
    bus_cs = 1'b0;
    rst_n  = 1'b1;
    model  = '0;
    check("R10 reset wins", 8'h00);
    access(line_addr(7, 1'b1), 1'b1);
    check("R8 mode after reset", model);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule